// File: doc/BRIEF.md
# Toggle-on-Write Interrupt Controller

This block gathers eight event lines from a serial bus peripheral into one level interrupt. Each event line is edge-detected, and its rising edge latches a bit in a status register. A per-source enable register and a single global enable bit decide which latched bits reach the interrupt pin. The sources are arbitration lost, transmit error or message complete, transmit queue empty, receive queue at its programmed level, bus idle, addressed as target, no longer addressed as target, and transmit queue half empty.

Software reaches the block over a simple 32-bit register port with a write strobe, a byte offset, write data and combinational read data. A write to the status register inverts every bit written as 1. Software uses this to acknowledge a pending source, and it can also raise any source on purpose. Writing a fixed key to a reset location returns all software-visible state to zero.

Top module: `irq_toggle_ctrl`

## Requirements
- R1: After reset, the status register, the enable register, the global enable bit and `irq` are all 0. Reads of every offset return 0.
- R2: A 0-to-1 transition on `events[i]` sets status bit i at the next clock edge. An event held high does not set the bit again. The bit map is: 0 arbitration lost, 1 transmit error/complete, 2 transmit empty, 3 receive at level, 4 bus idle, 5 addressed as target, 6 not addressed, 7 transmit half empty.
- R3: Status bits stay set until software changes them. They read at offset 0x20 in bits 7:0, whatever the enable and global enable settings are.
- R4: A write to offset 0x20 inverts each status bit whose `wdata` bit is 1. A set bit is cleared. A clear bit becomes set.
- R5: If an event edge and a status write hit the same bit in the same cycle, that bit ends up set.
- R6: The enable register sits at offset 0x28, bits 7:0, and reads back as written. A 1 enables the matching source.
- R7: The global enable is bit 31 of offset 0x1C and reads back in that position. The other bits of that write are ignored.
- R8: `irq` is a register. In each cycle it equals global enable AND the OR over i of (status[i] AND enable[i]), as these stood in the previous cycle.
- R9: Writing 0x0000000A to offset 0x40 clears status, enable, global enable and `irq` at the next edge. A level already high on an event input does not set its status bit again afterwards.
- R10: Any other value written to offset 0x40 has no effect. Offset 0x40 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W (8) | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| events | input | NSRC (8) | Event lines, edge-detected |
| irq | output | 1 | Level interrupt, registered |

## Verification
A hardware event edge and a software toggle write can fall on the same status bit in the same cycle. The bench provokes this by raising event 7 in the same cycle that it writes 1 to status bit 7 and to two other bits. It then expects bit 7 set and the other two inverted. A key write to the reset location can also coincide with an event input that is still held high. The bench expects the status to be cleared and to stay clear, with no second latch from that held level.

// File: rtl/irq_toggle_ctrl.sv
module irq_toggle_ctrl #(
  parameter int ADDR_W    = 8,
  parameter int NSRC      = 8,
  parameter logic [ADDR_W-1:0] GIE_OFS = 8'h1C,
  parameter logic [ADDR_W-1:0] STS_OFS = 8'h20,
  parameter logic [ADDR_W-1:0] ENA_OFS = 8'h28,
  parameter logic [ADDR_W-1:0] KEY_OFS = 8'h40,
  parameter logic [31:0]       KEY_VAL = 32'h0000_000A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [NSRC-1:0]   events,
  output logic              irq
);

  localparam int GIE_BIT = 31;

  logic [NSRC-1:0] sts_q, ena_q, ev_q, rise, tgl;
  logic            gie_q, irq_q;
  logic            wr_sts, wr_ena, wr_gie, wr_key;

  assign wr_sts = wr_en && (addr == STS_OFS);
  assign wr_ena = wr_en && (addr == ENA_OFS);
  assign wr_gie = wr_en && (addr == GIE_OFS);
  assign wr_key = wr_en && (addr == KEY_OFS) && (wdata == KEY_VAL);

  assign rise = events & ~ev_q;
  assign tgl  = wr_sts ? wdata[NSRC-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ev_q <= '0;
    else        ev_q <= events;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      ena_q <= '0;
      gie_q <= 1'b0;
      irq_q <= 1'b0;
    end else if (wr_key) begin
      sts_q <= '0;
      ena_q <= '0;
      gie_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      sts_q <= (sts_q ^ tgl) | rise;
      if (wr_ena) ena_q <= wdata[NSRC-1:0];
      if (wr_gie) gie_q <= wdata[GIE_BIT];
      irq_q <= gie_q & |(sts_q & ena_q);
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == GIE_OFS)      rdata[GIE_BIT]  = gie_q;
    else if (addr == STS_OFS) rdata[NSRC-1:0] = sts_q;
    else if (addr == ENA_OFS) rdata[NSRC-1:0] = ena_q;
  end

  assign irq = irq_q;

endmodule

module irq_toggle_ctrl_chk #(
  parameter int NSRC = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_sts,
  input logic            wr_ena,
  input logic            wr_key,
  input logic [NSRC-1:0] events,
  input logic [NSRC-1:0] ev_q,
  input logic [NSRC-1:0] sts_q,
  input logic [NSRC-1:0] ena_q,
  input logic            gie_q,
  input logic            irq
);

  // R8
  irq_needs_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(gie_q));

  // R8
  irq_needs_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(sts_q & ena_q) != '0));

  // R9
  key_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_key |=> (sts_q == '0 && ena_q == '0 && !gie_q && !irq));

  // R3
  sts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_sts && !wr_key && (events & ~ev_q) == '0) |=> $stable(sts_q));

  // R6
  ena_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ena && !wr_key) |=> $stable(ena_q));

  for (genvar i = 0; i < NSRC; i++) begin : g_edge
    // R2 R5
    edge_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (events[i] && !ev_q[i] && !wr_key) |=> sts_q[i]);
  end

endmodule

bind irq_toggle_ctrl irq_toggle_ctrl_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_sts(wr_sts), .wr_ena(wr_ena),
  .wr_key(wr_key), .events(events), .ev_q(ev_q), .sts_q(sts_q),
  .ena_q(ena_q), .gie_q(gie_q), .irq(irq)
);

// File: tb/sim_irq_toggle_ctrl.sv
`timescale 1ns/1ps
module sim_irq_toggle_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  events = '0;
  logic        irq;

  int n_run = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  irq_toggle_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .events(events), .irq(irq)
  );

  localparam logic [7:0] A_GIE = 8'h1C, A_STS = 8'h20, A_ENA = 8'h28, A_KEY = 8'h40;

  // {addr, we, wdata, events, expected status, expected irq}
  localparam int NV = 13;
  localparam logic [57:0] VEC [NV] = '{
    {A_STS, 1'b0, 32'h0,        8'h01, 8'h01, 1'b0}, // R2 R3 latch, no enable
    {A_ENA, 1'b1, 32'h1,        8'h01, 8'h01, 1'b0}, // R6 enabled, gie off
    {A_GIE, 1'b1, 32'h80000000, 8'h01, 8'h01, 1'b1}, // R8 gie on
    {A_STS, 1'b1, 32'h1,        8'h01, 8'h00, 1'b0}, // R4 clear by toggle
    {A_STS, 1'b1, 32'h4,        8'h01, 8'h04, 1'b0}, // R4 set by toggle, masked
    {A_ENA, 1'b1, 32'h4,        8'h01, 8'h04, 1'b1}, // R8 soft-raised source
    {A_GIE, 1'b1, 32'h0,        8'h00, 8'h04, 1'b0}, // R7 global mask
    {A_STS, 1'b0, 32'h0,        8'h02, 8'h06, 1'b0}, // R2 bit1 edge
    {A_STS, 1'b1, 32'h86,       8'h82, 8'h80, 1'b0}, // R5 edge and toggle
    {A_GIE, 1'b1, 32'h80000000, 8'h82, 8'h80, 1'b0}, // R8 bit7 not enabled
    {A_ENA, 1'b1, 32'h80,       8'h82, 8'h80, 1'b1}, // R8 bit7 enabled
    {A_KEY, 1'b1, 32'h5,        8'h82, 8'h80, 1'b1}, // R10 wrong key
    {A_KEY, 1'b1, 32'hA,        8'h82, 8'h00, 1'b0}  // R9 key clears
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, input string req, input logic [31:0] exp);
    addr = a;
    #0.5;
    check(req, rdata, exp);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_run++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(A_STS, "R1 status", 32'h0);
    rd(A_ENA, "R1 enable", 32'h0);
    rd(A_GIE, "R1 gie", 32'h0);
    rd(A_KEY, "R1 key reads 0", 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      addr = VEC[i][57:50]; wr_en = VEC[i][49];
      wdata = VEC[i][48:17]; events = VEC[i][16:9];
      @(negedge clk);
      wr_en = 1'b0;
      rd(A_STS, $sformatf("vec%0d status", i), {24'b0, VEC[i][8:1]});
      @(negedge clk);
      check($sformatf("vec%0d irq", i), {31'b0, irq}, {31'b0, VEC[i][0]});
    end

    // R9 held event does not relatch; registers cleared
    repeat (3) @(negedge clk);
    rd(A_STS, "R9 held event no relatch", 32'h0);
    rd(A_ENA, "R9 enable cleared", 32'h0);
    rd(A_GIE, "R9 gie cleared", 32'h0);

    // R7 only bit 31 counts
    wr(A_GIE, 32'h7FFFFFFF);
    rd(A_GIE, "R7 low bits ignored", 32'h0);
    wr(A_GIE, 32'hFFFFFFFF);
    rd(A_GIE, "R7 readback", 32'h80000000);

    // R6 readback
    wr(A_ENA, 32'hFFFFFF5A);
    rd(A_ENA, "R6 readback", 32'h5A);

    // R2 each event position
    events = 8'h00;
    @(negedge clk);
    events = 8'h28;
    @(negedge clk);
    rd(A_STS, "R2 bits 3 and 5", 32'h28);
    @(negedge clk);
    check("R8 irq from bit3", {31'b0, irq}, 32'h1);

    // R4 toggle all
    wr(A_STS, 32'hFF);
    rd(A_STS, "R4 toggle all", 32'hD7);
    wr(A_STS, 32'hD7);
    rd(A_STS, "R4 clear all", 32'h0);
    @(negedge clk);
    check("R8 irq drops", {31'b0, irq}, 32'h0);

    // R10 key on another offset ignored
    wr(A_STS, 32'h10);
    wr(8'h44, 32'hA);
    rd(A_STS, "R10 key elsewhere", 32'h10);

    // R1 async reset mid-run
    rst_n = 1'b0;
    #1;
    rd(A_STS, "R1 async reset status", 32'h0);
    check("R1 async reset irq", {31'b0, irq}, 32'h0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

endmodule